// File: doc/BRIEF.md
# Display Controller Frame Sequencer

This block is the control and status core of a simple display controller. Software writes a 32-bit control word that turns the controller on, picks the panel type, picks the load sequence and enables interrupts. The block then asks an external fetch engine for palette words, for frame data, or for both in turn. The raster timing logic outside the block supplies start-of-frame and end-of-frame pulses. The pixel path and the panel logic report events, which the block latches in a seven-bit status register and combines into one interrupt line.

Turning the controller off is graceful. If a frame is being fetched when the enable bit is cleared, fetching carries on until that frame's end-of-frame pulse. Only then does the controller stop and raise its done flag. The error flags (FIFO underflow and lost sync) cannot be cleared by software writes. Software recovers from an error by turning the controller off and on again.

The register interface is a single write strobe with a one-bit select: 0 for control, 1 for status. Both registers are always visible on output ports.

Top module: `frame_seq_ctrl`

## Requirements
- R1: After reset, the control word is 0, the status is 0, the interrupt is low and no fetch is requested.
- R2: A write with select 0 loads the whole control word, which reads back unchanged. Control bit 0 is enable, bit 7 is the active-matrix panel flag, and bits 21:20 are the load mode. A disabled controller requests no fetch.
- R3: Load mode 00 fetches the palette first: PAL_WORDS accepted words with fetch kind 0. It then sets status bit 6 (palette loaded) and stops requesting. From each start-of-frame pulse to the next end-of-frame pulse it requests frame data with fetch kind 1.
- R4: Load mode 01 fetches only the palette, sets status bit 6 and then idles. Start-of-frame pulses start no frame fetch.
- R5: Load modes 10 and 11 skip the palette. Every frame runs from a start-of-frame pulse to an end-of-frame pulse, and the sequence repeats for as long as the controller stays enabled.
- R6: If enable is cleared during a frame, fetching continues until end-of-frame, and then status bit 0 (done) is set. If enable is cleared between frames or during a palette load, done is set one cycle after the control write.
- R7: Done is cleared only by a control write that sets enable while it was clear. Status writes do not change done.
- R8: While enabled, the vsync, AC-bias and line-match inputs set status bits 1, 3 and 4, and the sync-loss input sets bit 2. Writing 1 to status bit 1, 3 or 4 clears that bit. Writing 0 leaves it unchanged. An event in the same cycle as a clear wins.
- R9: Status bit 5 (underflow) is set when the pixel path requests data while fetch_valid_i is low, but only while enable is set.
- R10: Status bits 2 and 5 are cleared only by a control write that clears enable. Status writes do not change them.
- R11: In load mode 01, writing 1 to status bit 6 clears it. In the other modes, status writes do not change bit 6, and it is cleared when enable is cleared.
- R12: irq_o is high when any of these holds: done with control bit 3, vsync with bit 2, palette loaded with bit 4, line match with bit 5 or bit 6, sync loss, or underflow. AC-bias never interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Write data |
| ctrl_o | output | 32 | Current control word |
| stat_o | output | 7 | Current status bits |
| irq_o | output | 1 | Interrupt request |
| sof_i | input | 1 | Start-of-frame pulse from raster timing |
| eof_i | input | 1 | End-of-frame pulse from raster timing |
| vsync_i | input | 1 | Vertical sync event |
| acb_i | input | 1 | AC-bias count event |
| line_i | input | 1 | Line-match event |
| sync_lost_i | input | 1 | Sync-loss event |
| pix_req_i | input | 1 | Pixel path requests data |
| fetch_valid_i | input | 1 | Fetch port has a valid word this cycle |
| fetch_req_o | output | 1 | Request words from the fetch port |
| fetch_kind_o | output | 1 | 0 palette words, 1 frame words |

## Verification
The hardest case to reach is a disable that lands in the middle of a frame. The bench must first get the controller past its palette load, or into frame-only mode, and then deliver a start-of-frame pulse. Only after that does it clear enable, and it holds back end-of-frame so it can watch fetching continue with done still low. It then pulses end-of-frame and checks that done rises and fetching stops in the same cycle. A second path clears enable while the controller is waiting between frames. In that case done must rise one cycle after the write, with no end-of-frame pulse.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PAL, S_PAL_HOLD, S_WAIT, S_FRAME
  } fsq_state_t;

  // status bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_VSYNC = 1;
  localparam int ST_SYNC  = 2;
  localparam int ST_ACB   = 3;
  localparam int ST_LINE  = 4;
  localparam int ST_UFLOW = 5;
  localparam int ST_PAL   = 6;
  localparam int ST_W     = 7;

  // control bit positions
  localparam int CT_EN      = 0;
  localparam int CT_IE_VS   = 2;
  localparam int CT_IE_DONE = 3;
  localparam int CT_IE_PAL  = 4;
  localparam int CT_IE_LN2  = 5;
  localparam int CT_IE_LN   = 6;
  localparam int CT_MODE_LO = 20;

  localparam logic [1:0] MODE_BOTH     = 2'b00;
  localparam logic [1:0] MODE_PAL_ONLY = 2'b01;
endpackage

// File: rtl/fsq_ctrl_reg.sv
module fsq_ctrl_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic         en_rise,
  output logic         en_fall
);
  import fsq_pkg::*;

  assign en_rise = wr_en &&  wdata[CT_EN] && !ctrl_q[CT_EN];
  assign en_fall = wr_en && !wdata[CT_EN] &&  ctrl_q[CT_EN];

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end
endmodule

// File: rtl/fsq_seq.sv
module fsq_seq #(
  parameter int PAL_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       sof,
  input  logic       eof,
  input  logic       fetch_valid,
  output logic       fetch_req,
  output logic       fetch_kind,
  output logic       pal_set,
  output logic       done_set
);
  import fsq_pkg::*;

  localparam int CW = (PAL_WORDS > 1) ? $clog2(PAL_WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PAL_WORDS - 1);

  fsq_state_t    st, nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt      = st;
    pal_set  = 1'b0;
    done_set = 1'b0;
    unique case (st)
      S_IDLE:
        if (enable)
          nxt = (mode == MODE_BOTH || mode == MODE_PAL_ONLY) ? S_PAL : S_WAIT;
      S_PAL:
        if (!enable) begin
          nxt = S_IDLE; done_set = 1'b1;
        end else if (fetch_valid && cnt == LAST) begin
          pal_set = 1'b1;
          nxt = (mode == MODE_PAL_ONLY) ? S_PAL_HOLD : S_WAIT;
        end
      S_PAL_HOLD:
        if (!enable) begin
          nxt = S_IDLE; done_set = 1'b1;
        end
      S_WAIT:
        if (!enable) begin
          nxt = S_IDLE; done_set = 1'b1;
        end else if (sof) nxt = S_FRAME;
      S_FRAME:
        if (eof) begin
          nxt = enable ? S_WAIT : S_IDLE;
          done_set = !enable;
        end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      fetch_req  <= 1'b0;
      fetch_kind <= 1'b0;
    end else begin
      st         <= nxt;
      cnt        <= (st == S_PAL && nxt == S_PAL) ? cnt + CW'(fetch_valid) : '0;
      fetch_req  <= (nxt == S_PAL) || (nxt == S_FRAME);
      fetch_kind <= (nxt == S_FRAME);
    end
  end
endmodule

// File: rtl/fsq_status.sv
module fsq_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       pal_w1c_ok,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic       wr_en,
  input  logic [6:0] wdata,
  input  logic       vsync,
  input  logic       acb,
  input  logic       line,
  input  logic       sync_lost,
  input  logic       uflow,
  input  logic       pal_set,
  input  logic       done_set,
  output logic [6:0] stat_q
);
  import fsq_pkg::*;

  // write-one-to-clear event bits, event wins over clear
  localparam int NEV = 3;
  localparam int EV_POS [NEV] = '{ST_VSYNC, ST_ACB, ST_LINE};
  logic [NEV-1:0] ev_in;
  assign ev_in = {line, acb, vsync};

  for (genvar g = 0; g < NEV; g++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst)                          stat_q[EV_POS[g]] <= 1'b0;
      else if (enable && ev_in[g])      stat_q[EV_POS[g]] <= 1'b1;
      else if (wr_en && wdata[EV_POS[g]]) stat_q[EV_POS[g]] <= 1'b0;
    end
  end

  // error bits: cleared only by disabling
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q[ST_SYNC]  <= 1'b0;
      stat_q[ST_UFLOW] <= 1'b0;
    end else if (en_fall) begin
      stat_q[ST_SYNC]  <= 1'b0;
      stat_q[ST_UFLOW] <= 1'b0;
    end else if (enable) begin
      if (sync_lost) stat_q[ST_SYNC]  <= 1'b1;
      if (uflow)     stat_q[ST_UFLOW] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      stat_q[ST_PAL] <= 1'b0;
    else if (en_fall)                             stat_q[ST_PAL] <= 1'b0;
    else if (pal_set)                             stat_q[ST_PAL] <= 1'b1;
    else if (wr_en && wdata[ST_PAL] && pal_w1c_ok) stat_q[ST_PAL] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           stat_q[ST_DONE] <= 1'b0;
    else if (en_rise)  stat_q[ST_DONE] <= 1'b0;
    else if (done_set) stat_q[ST_DONE] <= 1'b1;
  end
endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl #(
  parameter int CTRL_W    = 32,
  parameter int PAL_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [6:0]        stat_o,
  output logic              irq_o,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              vsync_i,
  input  logic              acb_i,
  input  logic              line_i,
  input  logic              sync_lost_i,
  input  logic              pix_req_i,
  input  logic              fetch_valid_i,
  output logic              fetch_req_o,
  output logic              fetch_kind_o
);
  import fsq_pkg::*;

  logic en_rise, en_fall, pal_set, done_set;
  logic [1:0] mode;

  fsq_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr && !reg_sel), .wdata(reg_wdata),
    .ctrl_q(ctrl_o), .en_rise(en_rise), .en_fall(en_fall)
  );

  assign mode = ctrl_o[CT_MODE_LO +: 2];

  fsq_seq #(.PAL_WORDS(PAL_WORDS)) u_seq (
    .clk(clk), .rst(rst), .enable(ctrl_o[CT_EN]), .mode(mode),
    .sof(sof_i), .eof(eof_i), .fetch_valid(fetch_valid_i),
    .fetch_req(fetch_req_o), .fetch_kind(fetch_kind_o),
    .pal_set(pal_set), .done_set(done_set)
  );

  fsq_status u_stat (
    .clk(clk), .rst(rst), .enable(ctrl_o[CT_EN]),
    .pal_w1c_ok(mode == MODE_PAL_ONLY), .en_rise(en_rise), .en_fall(en_fall),
    .wr_en(reg_wr && reg_sel), .wdata(reg_wdata[ST_W-1:0]),
    .vsync(vsync_i), .acb(acb_i), .line(line_i), .sync_lost(sync_lost_i),
    .uflow(pix_req_i && !fetch_valid_i), .pal_set(pal_set), .done_set(done_set),
    .stat_q(stat_o)
  );

  assign irq_o = (stat_o[ST_DONE]  && ctrl_o[CT_IE_DONE])
              || (stat_o[ST_VSYNC] && ctrl_o[CT_IE_VS])
              || (stat_o[ST_PAL]   && ctrl_o[CT_IE_PAL])
              || (stat_o[ST_LINE]  && (ctrl_o[CT_IE_LN] || ctrl_o[CT_IE_LN2]))
              ||  stat_o[ST_SYNC]  || stat_o[ST_UFLOW];
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] ctrl_o,
  input logic [6:0]  stat_o,
  input logic        irq_o,
  input logic        fetch_req_o
);
  // R7: enabling clears done
  p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_wdata[0] && !ctrl_o[0]) |=> !stat_o[0]);
  // R7: done stays until enabled
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_o[0] && !(reg_wr && !reg_sel && reg_wdata[0])) |=> stat_o[0]);
  // R10: disabling clears the error bits
  p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && !reg_wdata[0] && ctrl_o[0]) |=> (!stat_o[2] && !stat_o[5]));
  // R10: underflow held unless the control word is written
  p_uflow_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_o[5] && !(reg_wr && !reg_sel)) |=> stat_o[5]);
  // R12: no interrupt without a status bit
  p_irq_src_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (stat_o != 7'd0));
  // R1: nothing fetched right after reset
  p_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> !fetch_req_o);
endmodule

bind frame_seq_ctrl fsq_checker u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .ctrl_o(ctrl_o), .stat_o(stat_o), .irq_o(irq_o),
  .fetch_req_o(fetch_req_o)
);

// File: tb/tb_frame_seq_ctrl.sv
`timescale 1ns/1ps
module tb_frame_seq_ctrl;
  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_o;
  logic [6:0]  stat_o;
  logic irq_o, fetch_req_o, fetch_kind_o;
  logic sof_i = 0, eof_i = 0, vsync_i = 0, acb_i = 0, line_i = 0;
  logic sync_lost_i = 0, pix_req_i = 0, fetch_valid_i = 0;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  frame_seq_ctrl dut (.*);

  // {vsync, acb, line, sync_lost, pix_req, fetch_valid} -> {status, irq}
  localparam logic [13:0] VEC [8] = '{
    {6'b100000, 7'h02, 1'b1},
    {6'b010000, 7'h08, 1'b0},
    {6'b001000, 7'h10, 1'b1},
    {6'b000100, 7'h04, 1'b1},
    {6'b000010, 7'h20, 1'b1},
    {6'b000011, 7'h00, 1'b0},
    {6'b101000, 7'h12, 1'b1},
    {6'b000000, 7'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_sel = 0; reg_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    cyc(2); rst = 0;
  endtask

  task automatic pulse_sof(); sof_i = 1; cyc(1); sof_i = 0; endtask
  task automatic pulse_eof(); eof_i = 1; cyc(1); eof_i = 0; endtask

  task automatic feed_palette();
    cyc(1);
    fetch_valid_i = 1; cyc(4); fetch_valid_i = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 stat", {25'd0, stat_o}, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 fetch", {31'd0, fetch_req_o}, 0);

    // vector table: frame-only mode, all interrupt enables set
    for (int v = 0; v < 8; v++) begin
      do_reset();
      wr(0, 32'h0020_007D);
      {vsync_i, acb_i, line_i, sync_lost_i, pix_req_i, fetch_valid_i} = VEC[v][13:8];
      cyc(1);
      {vsync_i, acb_i, line_i, sync_lost_i, pix_req_i, fetch_valid_i} = '0;
      chk("R8/R9 vec stat", {25'd0, stat_o}, {25'd0, VEC[v][7:1]});
      chk("R12 vec irq", {31'd0, irq_o}, {31'd0, VEC[v][0]});
    end

    // R8 write-one-to-clear of event bits
    do_reset();
    wr(0, 32'h0020_0001);
    vsync_i = 1; acb_i = 1; line_i = 1; cyc(1);
    vsync_i = 0; acb_i = 0; line_i = 0;
    chk("R12 irq masked", {31'd0, irq_o}, 0);
    wr(1, 32'h0000_0008);
    chk("R8 w1c acb only", {25'd0, stat_o}, 32'h12);
    wr(1, 32'h0000_0012);
    chk("R8 w1c rest", {25'd0, stat_o}, 0);

    // R2 control readback
    do_reset();
    wr(0, 32'h0000_0080);
    cyc(1);
    chk("R2 readback", ctrl_o, 32'h80);
    chk("R2 no fetch", {31'd0, fetch_req_o}, 0);

    // R3 palette then frame, R6 graceful disable, R7, R11
    do_reset();
    wr(0, 32'h0000_0001);
    cyc(1);
    chk("R3 pal req", {30'd0, fetch_req_o, fetch_kind_o}, 32'h2);
    fetch_valid_i = 1; cyc(4); fetch_valid_i = 0;
    chk("R3 pal loaded", {31'd0, stat_o[6]}, 1);
    chk("R3 wait sof", {31'd0, fetch_req_o}, 0);
    wr(1, 32'h0000_0040);
    chk("R11 no w1c mode00", {31'd0, stat_o[6]}, 1);
    pulse_sof();
    chk("R3 frame req", {30'd0, fetch_req_o, fetch_kind_o}, 32'h3);
    wr(0, 32'h0000_0008);
    chk("R6 still fetching", {31'd0, fetch_req_o}, 1);
    chk("R6 no done yet", {31'd0, stat_o[0]}, 0);
    chk("R11 pal cleared by disable", {31'd0, stat_o[6]}, 0);
    cyc(3);
    chk("R6 holds until eof", {31'd0, fetch_req_o}, 1);
    pulse_eof();
    chk("R6 done", {31'd0, stat_o[0]}, 1);
    chk("R6 stopped", {31'd0, fetch_req_o}, 0);
    chk("R12 done irq", {31'd0, irq_o}, 1);
    wr(1, 32'h0000_007F);
    chk("R7 write ignored", {31'd0, stat_o[0]}, 1);
    wr(0, 32'h0000_0001);
    chk("R7 cleared by enable", {31'd0, stat_o[0]}, 0);

    // R4 palette only
    do_reset();
    wr(0, 32'h0010_0011);
    feed_palette();
    chk("R4 pal loaded", {31'd0, stat_o[6]}, 1);
    chk("R12 pal irq", {31'd0, irq_o}, 1);
    chk("R4 idle", {31'd0, fetch_req_o}, 0);
    pulse_sof();
    chk("R4 sof ignored", {31'd0, fetch_req_o}, 0);
    wr(1, 32'h0000_0040);
    chk("R11 w1c mode01", {31'd0, stat_o[6]}, 0);

    // R5 frame-only loop, R6 disable between frames
    do_reset();
    wr(0, 32'h0030_0001);
    cyc(1);
    chk("R5 no palette", {31'd0, fetch_req_o}, 0);
    pulse_sof();
    chk("R5 frame1", {30'd0, fetch_req_o, fetch_kind_o}, 32'h3);
    pulse_eof();
    chk("R5 gap", {31'd0, fetch_req_o}, 0);
    chk("R5 no done", {31'd0, stat_o[0]}, 0);
    pulse_sof();
    chk("R5 frame2", {30'd0, fetch_req_o, fetch_kind_o}, 32'h3);
    pulse_eof();
    wr(0, 32'h0030_0000);
    cyc(1);
    chk("R6 done between frames", {31'd0, stat_o[0]}, 1);

    // R9/R10 error bits
    do_reset();
    wr(0, 32'h0020_0001);
    sync_lost_i = 1; pix_req_i = 1; cyc(1);
    sync_lost_i = 0; pix_req_i = 0;
    chk("R12 errors irq", {31'd0, irq_o}, 1);
    wr(1, 32'h0000_007F);
    chk("R10 write ignored", {25'd0, stat_o} & 32'h24, 32'h24);
    wr(0, 32'h0020_0000);
    chk("R10 cleared by disable", {25'd0, stat_o} & 32'h24, 0);
    pix_req_i = 1; cyc(1); pix_req_i = 0;
    chk("R9 no underflow disabled", {31'd0, stat_o[5]}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule